// File: doc/BRIEF.md
# ADC Result Queue Unit

This block collects conversion results from an ADC sequencer and files each one into one of four independent FIFO queues. Every incoming result carries a 10-bit sample, a channel number and a two-bit queue index taken from the conversion command that produced it. Queues 0 and 1 hold sixteen entries each. Queues 2 and 3 hold four entries each.

Each queue presents its oldest entry on its own 32-bit read word, and a one-cycle pop strobe removes that entry. A shared configuration bit picks left or right justification of the sample inside a 16-bit field. A second bit picks a 32-bit read format that adds the channel number in the upper half. Each queue drives a DMA request line while it holds data. Each queue also reports empty, full and a sticky overflow flag.

Top module: `adc_rq_top`

## Requirements
- R1: A result with `wr_valid` high is stored only in the queue whose index equals `wr_q`. The other queues are unchanged.
- R2: Queues 0 and 1 accept 16 entries. When a queue is full, a further write is dropped and the stored contents are unchanged.
- R3: Queues 2 and 3 accept 4 entries. When a queue is full, a further write is dropped.
- R4: Each queue returns its entries in the order they were written.
- R5: With `left_just` = 0 the sample appears in bits [9:0] of the queue's read word, and bits [15:10] are zero.
- R6: With `left_just` = 1 the sample appears in bits [15:6], and bits [5:0] are zero.
- R7: With `wide_read` = 1, bits [31:16] hold the channel number zero-extended. With `wide_read` = 0, bits [31:16] are zero. Justification applies at read time to the entry at the head of the queue.
- R8: `q_empty[n]` is 1 when queue n holds no entry. `q_full[n]` is 1 when queue n holds its full depth.
- R9: A write to a full queue sets `q_ovf[n]`. The flag stays set until a cycle with `ovf_clr[n]` = 1 and no new overflow. If a new overflow and a clear arrive in the same cycle, the flag stays set.
- R10: `dma_req[n]` is 1 exactly while queue n is not empty.
- R11: Each `rd_pop[n]` pulse removes exactly one entry. A pop of an empty queue has no effect. A write and a pop in the same cycle on a queue that is not full keep its fill level.
- R12: After reset, all queues are empty, and no request or overflow flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| left_just | input | 1 | 1 = left-justify sample, 0 = right-justify |
| wide_read | input | 1 | 1 = channel number in read bits [31:16] |
| wr_valid | input | 1 | Result write strobe |
| wr_q | input | 2 | Target queue index |
| wr_chan | input | 5 | Channel number of the result |
| wr_res | input | 10 | Raw conversion sample |
| rd_pop | input | 4 | Per-queue pop strobe |
| ovf_clr | input | 4 | Per-queue write-1 overflow clear |
| rd_data | output | 128 | Head word of queue n at bits [32n+31:32n] |
| q_empty | output | 4 | Per-queue empty flag |
| q_full | output | 4 | Per-queue full flag |
| q_ovf | output | 4 | Per-queue sticky overflow flag |
| dma_req | output | 4 | Per-queue DMA request |

## Verification
Results are written with distinct sample values and channel numbers. This lets a misrouted, reordered or duplicated entry show as a wrong word rather than a coincidental match.

One entry is read under all four combinations of justification and width. This separates a wrong bit placement from a wrong channel field.

Both a deep queue and a shallow queue are filled past their depth. This shows that each depth is honoured and that the dropped write leaves the stored sequence intact.

Pops of an empty queue, a write and a pop in the same cycle, and an overflow that coincides with a clear cover the edge interactions of the fill counter and the sticky flag.

// File: rtl/adc_rq_pkg.sv
package adc_rq_pkg;
  localparam int unsigned NUM_Q  = 4;
  localparam int unsigned QIDX_W = $clog2(NUM_Q);
  localparam int unsigned HALF_W = 16;

  typedef enum logic {
    JUST_RIGHT = 1'b0,
    JUST_LEFT  = 1'b1
  } just_e;
endpackage

// File: rtl/adc_rq_fifo.sv
module adc_rq_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         ovf_clr,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, wr_ptr_nx, rd_ptr, rd_ptr_nx;
  logic [CW-1:0] count, count_nx;
  logic          ovf_nx;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    count_nx  = count;
    if (push_ok) wr_ptr_nx = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    if (pop_ok)  rd_ptr_nx = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    if (push_ok && !pop_ok)      count_nx = count + 1'b1;
    else if (pop_ok && !push_ok) count_nx = count - 1'b1;
    ovf_nx = (ovf && !ovf_clr) || (push && full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      count  <= count_nx;
      ovf    <= ovf_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  // R8: fill level never exceeds the depth
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R2/R3: a dropped write leaves the fill level untouched
  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
  // R9: a write to a full queue raises overflow
  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push) |=> ovf);
  // R9: overflow is sticky without a clear
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  // R11: a lone pop removes exactly one entry
  p_pop_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (count == $past(count) - 1'b1));
  // R11: a pop of an empty queue does nothing
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
  // R10: an accepted write makes the queue non-empty
  p_req_after_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> !empty);
endmodule

// File: rtl/adc_rq_align.sv
module adc_rq_align #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned CH_W  = 5
) (
  input  logic [RES_W-1:0] res,
  input  logic [CH_W-1:0]  chan,
  input  logic             left_just,
  input  logic             wide_read,
  output logic [31:0]      word
);
  import adc_rq_pkg::*;
  localparam int unsigned PAD = HALF_W - RES_W;
  localparam int unsigned CPAD = HALF_W - CH_W;

  logic [HALF_W-1:0] lo_half, hi_half;

  always_comb begin
    if (just_e'(left_just) == JUST_LEFT) lo_half = {res, {PAD{1'b0}}};
    else                                 lo_half = {{PAD{1'b0}}, res};
    hi_half = wide_read ? {{CPAD{1'b0}}, chan} : '0;
    word    = {hi_half, lo_half};
  end

  // R7: upper half is zero in 16-bit mode
  always_comb begin
    if (!wide_read) a_narrow_hi_r7: assert (word[31:16] == '0);
  end
endmodule

// File: rtl/adc_rq_top.sv
module adc_rq_top #(
  parameter int unsigned RES_W   = 10,
  parameter int unsigned CH_W    = 5,
  parameter int unsigned DEEP    = 16,
  parameter int unsigned SHALLOW = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  left_just,
  input  logic                                  wide_read,
  input  logic                                  wr_valid,
  input  logic [adc_rq_pkg::QIDX_W-1:0]         wr_q,
  input  logic [CH_W-1:0]                       wr_chan,
  input  logic [RES_W-1:0]                      wr_res,
  input  logic [adc_rq_pkg::NUM_Q-1:0]          rd_pop,
  input  logic [adc_rq_pkg::NUM_Q-1:0]          ovf_clr,
  output logic [32*adc_rq_pkg::NUM_Q-1:0]       rd_data,
  output logic [adc_rq_pkg::NUM_Q-1:0]          q_empty,
  output logic [adc_rq_pkg::NUM_Q-1:0]          q_full,
  output logic [adc_rq_pkg::NUM_Q-1:0]          q_ovf,
  output logic [adc_rq_pkg::NUM_Q-1:0]          dma_req
);
  import adc_rq_pkg::*;
  localparam int unsigned EW = CH_W + RES_W;

  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    localparam int unsigned D = (q < 2) ? DEEP : SHALLOW;
    logic          push;
    logic [EW-1:0] head;

    assign push = wr_valid && (wr_q == QIDX_W'(q));

    adc_rq_fifo #(.DEPTH(D), .W(EW)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .push     (push),
      .push_data({wr_chan, wr_res}),
      .pop      (rd_pop[q]),
      .ovf_clr  (ovf_clr[q]),
      .head     (head),
      .empty    (q_empty[q]),
      .full     (q_full[q]),
      .ovf      (q_ovf[q])
    );

    adc_rq_align #(.RES_W(RES_W), .CH_W(CH_W)) u_align (
      .res      (head[RES_W-1:0]),
      .chan     (head[EW-1:RES_W]),
      .left_just(left_just),
      .wide_read(wide_read),
      .word     (rd_data[32*q +: 32])
    );

    assign dma_req[q] = !q_empty[q];

    // R1: a write aimed at another queue leaves this one's fill unchanged
    p_route_r1: assert property (@(posedge clk) disable iff (!rst_n_i)
      (wr_valid && wr_q != QIDX_W'(q) && !rd_pop[q]) |=> $stable(q_empty[q]) && $stable(q_full[q]));
  end

  // R12: flags clear while held in reset
  p_reset_state_r12: assert property (@(posedge clk)
    (!rst_n_i) |-> (q_ovf == '0 && dma_req == '0));
endmodule

// File: tb/adc_rq_top_test.sv
module adc_rq_top_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         left_just, wide_read, wr_valid;
  logic [1:0]   wr_q;
  logic [4:0]   wr_chan;
  logic [9:0]   wr_res;
  logic [3:0]   rd_pop, ovf_clr;
  logic [127:0] rd_data;
  logic [3:0]   q_empty, q_full, q_ovf, dma_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_rq_top uut (.*);

  function automatic logic [31:0] fmt(input logic [9:0] r, input logic [4:0] c,
                                      input logic lj, input logic wd);
    logic [15:0] lo;
    lo = lj ? {r, 6'b0} : {6'b0, r};
    return {wd ? {11'b0, c} : 16'b0, lo};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int q, input logic [9:0] r, input logic [4:0] c, input logic [3:0] clr = 0);
    @(negedge clk);
    wr_valid = 1; wr_q = 2'(q); wr_res = r; wr_chan = c; ovf_clr = clr;
    @(negedge clk);
    wr_valid = 0; ovf_clr = 0;
  endtask

  task automatic pop(input int q);
    @(negedge clk); rd_pop[q] = 1'b1;
    @(negedge clk); rd_pop = 0;
  endtask

  task automatic clr_ovf(input int q);
    @(negedge clk); ovf_clr[q] = 1'b1;
    @(negedge clk); ovf_clr = 0;
  endtask

  function automatic logic [31:0] word(input int q);
    return rd_data[32*q +: 32];
  endfunction

  task automatic t_reset;
    chk(q_empty == 4'hF, "R12 empty", 32'(q_empty), 32'hF);
    chk(q_full == 0 && q_ovf == 0, "R12 full/ovf", {q_full, q_ovf}, 0);
    chk(dma_req == 0, "R12 dma", 32'(dma_req), 0);
  endtask

  task automatic t_route_align;
    push(2, 10'h2A5, 5'd19);
    chk(q_empty == 4'b1011, "R1 routing", 32'(q_empty), 32'hB);
    chk(dma_req == 4'b0100, "R10 dma_req", 32'(dma_req), 32'h4);
    for (int m = 0; m < 4; m++) begin
      left_just = m[0]; wide_read = m[1];
      #1;
      chk(word(2) == fmt(10'h2A5, 5'd19, m[0], m[1]),
          m[1] ? "R7 wide" : (m[0] ? "R6 left" : "R5 right"), word(2), fmt(10'h2A5, 5'd19, m[0], m[1]));
    end
    left_just = 0; wide_read = 1;
    pop(2);
    chk(q_empty[2] && !dma_req[2], "R11 single pop empties", {q_empty, dma_req}, 32'hF0);
  endtask

  task automatic t_order;
    wide_read = 1;
    for (int i = 0; i < 3; i++) push(0, 10'(10'h100 + i * 7), 5'(i + 1));
    for (int i = 0; i < 3; i++) begin
      chk(word(0) == fmt(10'(10'h100 + i * 7), 5'(i + 1), 0, 1), "R4 order", word(0), fmt(10'(10'h100 + i * 7), 5'(i + 1), 0, 1));
      pop(0);
    end
    chk(q_empty[0], "R11 drained", 32'(q_empty), 32'hF);
  endtask

  task automatic t_deep;
    for (int i = 0; i < 16; i++) push(1, 10'(10'h200 + i), 5'(i));
    chk(q_full[1] && !q_ovf[1], "R2 deep full at 16", {q_full, q_ovf}, 32'h20);
    push(1, 10'h3FF, 5'd31);
    chk(q_ovf[1] && q_full[1], "R9 deep overflow", {q_full, q_ovf}, 32'h22);
    for (int i = 0; i < 16; i++) begin
      chk(word(1) == fmt(10'(10'h200 + i), 5'(i), 0, 1), "R2 deep contents", word(1), fmt(10'(10'h200 + i), 5'(i), 0, 1));
      pop(1);
    end
    chk(q_empty[1] && q_ovf[1], "R9 ovf sticky after drain", {q_empty, q_ovf}, 32'hF2);
    clr_ovf(1);
    chk(!q_ovf[1], "R9 clear", 32'(q_ovf), 0);
  endtask

  task automatic t_shallow;
    for (int i = 0; i < 3; i++) push(3, 10'(10'h050 + i), 5'(i + 8));
    chk(!q_full[3], "R8 not full at 3", 32'(q_full), 0);
    push(3, 10'h053, 5'd11);
    chk(q_full[3] && !q_ovf[3], "R3 shallow full at 4", {q_full, q_ovf}, 32'h80);
    push(3, 10'h0EE, 5'd1);
    chk(q_ovf == 4'b1000, "R9 shallow overflow only q3", 32'(q_ovf), 32'h8);
    clr_ovf(3);
    chk(!q_ovf[3], "R9 clear q3", 32'(q_ovf), 0);
    push(3, 10'h0EF, 5'd2, 4'b1000);
    chk(q_ovf[3], "R9 set wins over clear", 32'(q_ovf), 32'h8);
    clr_ovf(3);
    for (int i = 0; i < 4; i++) begin
      chk(word(3) == fmt(10'(10'h050 + i), 5'(i + 8), 0, 1), "R3 shallow contents", word(3), fmt(10'(10'h050 + i), 5'(i + 8), 0, 1));
      pop(3);
    end
    chk(q_empty[3], "R8 shallow empty", 32'(q_empty), 32'hF);
  endtask

  task automatic t_edge;
    pop(0);
    chk(q_empty[0] && !dma_req[0], "R11 pop of empty", {q_empty, dma_req}, 32'hF0);
    push(0, 10'h011, 5'd3);
    push(0, 10'h022, 5'd4);
    @(negedge clk);
    wr_valid = 1; wr_q = 0; wr_res = 10'h033; wr_chan = 5'd5; rd_pop = 4'b0001;
    @(negedge clk);
    wr_valid = 0; rd_pop = 0;
    chk(word(0) == fmt(10'h022, 5'd4, 0, 1), "R11 push+pop head", word(0), fmt(10'h022, 5'd4, 0, 1));
    pop(0);
    chk(word(0) == fmt(10'h033, 5'd5, 0, 1), "R11 push+pop level", word(0), fmt(10'h033, 5'd5, 0, 1));
    pop(0);
    chk(q_empty == 4'hF, "R8 all empty", 32'(q_empty), 32'hF);
  endtask

  initial begin
    rst_n = 0; left_just = 0; wide_read = 0; wr_valid = 0; wr_q = 0;
    wr_chan = 0; wr_res = 0; rd_pop = 0; ovf_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_route_align();
    t_order();
    t_deep();
    t_shallow();
    t_edge();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule